// File: doc/BRIEF.md
# Serial Sentence Framer

The block watches a stream of received bytes, each qualified by a valid strobe, and picks out text sentences that open with the three characters `$`, `G`, `P` and close with a carriage return followed by a line feed. The payload bytes between the opening characters and the closing pair go into an on-block message store, and a length counter tracks them. When the closing pair arrives intact, the block raises a one-cycle completion strobe together with the payload length. Software or a downstream parser then reads the stored bytes through a combinational read port.

A broken opening sequence or a carriage return that is not followed by a line feed drops the sentence without any indication. The machine then goes back to hunting for the next `$`. A payload longer than the store aborts the sentence and raises a one-cycle overflow pulse. If the state register ever holds an encoding that belongs to no state, the block raises an error pulse and forces the machine back to hunting.

The machine has five states:
- HUNT waits for `$`.
- HDR_G expects `G`.
- HDR_P expects `P` and clears the length.
- BODY stores payload bytes.
- WAIT_LF expects the line feed.

The transitions are:
- HUNT to HDR_G on `$`.
- HDR_G to HDR_P on `G`.
- HDR_G to HUNT on any other byte.
- HDR_P to BODY on `P`.
- HDR_P to HUNT on any other byte.
- BODY to BODY on a stored byte.
- BODY to WAIT_LF on carriage return.
- BODY to HUNT on overflow.
- WAIT_LF to HUNT on line feed, which delivers the sentence.
- WAIT_LF to HUNT on any other byte, which discards it.
- Any illegal encoding to HUNT, with an error pulse.

Top module: `sentence_framer`

## Requirements
- R1: After reset, `done`, `overflow` and `state_err` are low and the machine is in HUNT.
- R2: A byte is consumed only in a cycle where `rx_valid` is high. A byte presented with `rx_valid` low changes neither the state nor the outputs.
- R3: In HUNT, every byte other than `$` (0x24) is ignored, and `$` moves the machine to HDR_G.
- R4: In HDR_G, `G` (0x47) moves to HDR_P. Any other byte, including a second `$`, returns to HUNT.
- R5: In HDR_P, `P` (0x50) enters BODY with the length set to zero. Any other byte returns to HUNT.
- R6: In BODY, each byte other than carriage return (0x0D) is written to the store at the address equal to the current length, and the length then increments. A `$` in BODY is stored as payload and does not restart the sentence. `rd_data` shows the stored byte at `rd_addr` in the same cycle.
- R7: A carriage return in BODY followed by a line feed (0x0A) raises `done` for exactly one cycle. That cycle is the one after the line feed is accepted, and in it `done_len` equals the number of payload bytes, which may be zero. The machine then returns to HUNT.
- R8: If the byte after the carriage return is not a line feed, the sentence is discarded without `done` and the machine returns to HUNT.
- R9: A payload of exactly MAX_LEN (80) bytes is delivered normally. A further non-carriage-return byte raises `overflow` for one cycle, in the cycle after it is accepted, and returns the machine to HUNT without `done`. `done` and `overflow` are never high together.
- R10: An illegal state encoding raises `state_err` in the cycle after it is seen and forces the machine to HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Qualifies `rx_byte` for the current cycle |
| rx_byte | input | 8 | Received byte |
| rd_addr | input | ADDR_W (7) | Message store read address |
| rd_data | output | 8 | Stored byte at `rd_addr` (combinational) |
| done | output | 1 | One-cycle pulse: sentence delivered |
| done_len | output | LEN_W (7) | Payload length, valid while `done` is high |
| overflow | output | 1 | One-cycle pulse: payload exceeded MAX_LEN |
| state_err | output | 1 | Pulse: illegal state encoding was detected |

## Verification
The illegal-state recovery is the hardest situation to reach from the ports, because no sequence of bytes can drive the state register outside its five legal encodings. The stimulus therefore overrides the state register with an unused encoding for one clock edge. It then watches `state_err` pulse and confirms that a complete sentence is framed normally afterwards. The overflow boundary needs a long payload: exactly 80 bytes must still be delivered, while an 81st byte must produce `overflow` and no `done`.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_HDR_G   = 3'd1,
        ST_HDR_P   = 3'd2,
        ST_BODY    = 3'd3,
        ST_WAIT_LF = 3'd4
    } state_t;

    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_G      = 8'h47;
    localparam logic [7:0] CH_P      = 8'h50;
    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;

endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
    import framer_pkg::*;
#(
    parameter int MAX_LEN = 80,
    parameter int LEN_W   = 7,
    parameter int ADDR_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done_o,
    output logic [LEN_W-1:0]  done_len_o,
    output logic              ovf_o,
    output logic              err_o
);

    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    state_t           state_q, state_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic             ev_done, ev_ovf, ev_err, ev_store;

    // next-state and event decode
    always_comb begin
        state_d  = state_q;
        len_d    = len_q;
        ev_done  = 1'b0;
        ev_ovf   = 1'b0;
        ev_err   = 1'b0;
        ev_store = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (in_valid && in_byte == CH_DOLLAR) state_d = ST_HDR_G;
            end
            ST_HDR_G: begin
                if (in_valid) state_d = (in_byte == CH_G) ? ST_HDR_P : ST_HUNT;
            end
            ST_HDR_P: begin
                if (in_valid) begin
                    if (in_byte == CH_P) begin
                        state_d = ST_BODY;
                        len_d   = '0;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
            end
            ST_BODY: begin
                if (in_valid) begin
                    if (in_byte == CH_CR) begin
                        state_d = ST_WAIT_LF;
                    end else if (len_q == LEN_LIMIT) begin
                        ev_ovf  = 1'b1;
                        state_d = ST_HUNT;
                    end else begin
                        ev_store = 1'b1;
                        len_d    = len_q + 1'b1;
                    end
                end
            end
            ST_WAIT_LF: begin
                if (in_valid) begin
                    state_d = ST_HUNT;
                    ev_done = (in_byte == CH_LF);
                end
            end
            default: begin
                state_d = ST_HUNT;
                ev_err  = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            done_len_o <= '0;
            ovf_o      <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            done_o <= ev_done;
            ovf_o  <= ev_ovf;
            err_o  <= ev_err;
            if (ev_done) done_len_o <= len_q;
        end
    end

    assign wr_en   = ev_store;
    assign wr_addr = ADDR_W'(len_q);
    assign wr_data = in_byte;

endmodule

// File: rtl/framer_store.sv
module framer_store #(
    parameter int DEPTH  = 80,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    generate
        if (DEPTH == (1 << ADDR_W)) begin : g_full
            assign rd_data = mem[rd_addr];
        end else begin : g_guard
            assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/sentence_framer.sv
module sentence_framer #(
    parameter int  MAX_LEN = 80,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int ADDR_W  = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output logic              overflow,
    output logic              state_err
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    framer_ctrl #(
        .MAX_LEN(MAX_LEN),
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_byte   (rx_byte),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done_o    (done),
        .done_len_o(done_len),
        .ovf_o     (overflow),
        .err_o     (state_err)
    );

    framer_store #(
        .DEPTH (MAX_LEN),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/framer_checker.sv
module framer_checker
    import framer_pkg::*;
#(
    parameter int MAX_LEN = 80,
    parameter int LEN_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             done,
    input logic [LEN_W-1:0] done_len,
    input logic             overflow
);

    // R7: delivery follows an accepted line feed
    assert_done_after_lf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid && rx_byte == CH_LF));

    // R7: delivery strobe lasts one cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: delivery and overflow exclusive
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, overflow}));

    // R9: delivered length never exceeds the store
    assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(done_len) <= MAX_LEN));

    // R9: overflow is caused by an accepted non-CR byte
    assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(rx_valid && rx_byte != CH_CR));

    // R2: an idle cycle produces no event
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!done && !overflow));

endmodule

bind sentence_framer framer_checker #(
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_byte (rx_byte),
    .done    (done),
    .done_len(done_len),
    .overflow(overflow)
);

// File: tb/sentence_framer_bench.sv
`timescale 1ns/1ps
module sentence_framer_bench;

    localparam int MAX = 80;
    localparam int NV  = 55;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       done;
    logic [6:0] done_len;
    logic       overflow;
    logic       state_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sentence_framer u_sentence_framer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .done_len(done_len),
        .overflow(overflow), .state_err(state_err)
    );

    // {req[3:0], valid, byte[7:0], exp_done, exp_ovf, exp_len[6:0]}
    localparam logic [21:0] VEC [NV] = '{
        // R7 basic sentence, two payload bytes
        {4'd7, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0}, {4'd7, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0},
        {4'd7, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0}, {4'd7, 1'b1, 8'h61, 1'b0, 1'b0, 7'd0},
        {4'd7, 1'b1, 8'h62, 1'b0, 1'b0, 7'd0}, {4'd7, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0},
        {4'd7, 1'b1, 8'h0A, 1'b1, 1'b0, 7'd2},
        // R3 garbage in hunt, R2 bytes with valid low ignored
        {4'd3, 1'b1, 8'h78, 1'b0, 1'b0, 7'd0}, {4'd2, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0},
        {4'd2, 1'b0, 8'h51, 1'b0, 1'b0, 7'd0}, {4'd2, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0},
        {4'd2, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0}, {4'd2, 1'b0, 8'h0D, 1'b0, 1'b0, 7'd0},
        {4'd2, 1'b1, 8'h5A, 1'b0, 1'b0, 7'd0}, {4'd2, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0},
        {4'd2, 1'b0, 8'h0A, 1'b0, 1'b0, 7'd0}, {4'd2, 1'b1, 8'h0A, 1'b1, 1'b0, 7'd1},
        // R4 wrong second character
        {4'd4, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0}, {4'd4, 1'b1, 8'h58, 1'b0, 1'b0, 7'd0},
        {4'd4, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0}, {4'd4, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0},
        {4'd4, 1'b1, 8'h31, 1'b0, 1'b0, 7'd0}, {4'd4, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0},
        {4'd4, 1'b1, 8'h0A, 1'b0, 1'b0, 7'd0},
        // R4 second dollar aborts
        {4'd4, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0}, {4'd4, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0},
        {4'd4, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0}, {4'd4, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0},
        {4'd4, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0}, {4'd4, 1'b1, 8'h0A, 1'b0, 1'b0, 7'd0},
        // R5 wrong third character
        {4'd5, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0}, {4'd5, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0},
        {4'd5, 1'b1, 8'h51, 1'b0, 1'b0, 7'd0}, {4'd5, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0},
        {4'd5, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0}, {4'd5, 1'b1, 8'h0A, 1'b0, 1'b0, 7'd0},
        // R8 CR followed by a non-LF byte
        {4'd8, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0}, {4'd8, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0},
        {4'd8, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0}, {4'd8, 1'b1, 8'h6B, 1'b0, 1'b0, 7'd0},
        {4'd8, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0}, {4'd8, 1'b1, 8'h6D, 1'b0, 1'b0, 7'd0},
        {4'd8, 1'b1, 8'h0A, 1'b0, 1'b0, 7'd0},
        // R7 empty payload
        {4'd7, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0}, {4'd7, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0},
        {4'd7, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0}, {4'd7, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0},
        {4'd7, 1'b1, 8'h0A, 1'b1, 1'b0, 7'd0},
        // R6 dollar inside payload is data
        {4'd6, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0}, {4'd6, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0},
        {4'd6, 1'b1, 8'h50, 1'b0, 1'b0, 7'd0}, {4'd6, 1'b1, 8'h24, 1'b0, 1'b0, 7'd0},
        {4'd6, 1'b1, 8'h47, 1'b0, 1'b0, 7'd0}, {4'd6, 1'b1, 8'h0D, 1'b0, 1'b0, 7'd0},
        {4'd6, 1'b1, 8'h0A, 1'b1, 1'b0, 7'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(input logic v, input logic [7:0] b);
        rx_valid = v;
        rx_byte  = b;
        @(negedge clk);
    endtask

    task automatic header();
        step(1'b1, 8'h24);
        step(1'b1, 8'h47);
        step(1'b1, 8'h50);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done after reset", int'(done), 0);
        chk("R1 overflow after reset", int'(overflow), 0);
        chk("R1 state_err after reset", int'(state_err), 0);
        step(1'b1, 8'h0A);
        chk("R1 no delivery from hunt", int'(done), 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17], VEC[i][16:9]);
            chk($sformatf("R%0d vec %0d done", VEC[i][21:18], i), int'(done), int'(VEC[i][8]));
            chk($sformatf("R%0d vec %0d overflow", VEC[i][21:18], i), int'(overflow), int'(VEC[i][7]));
            if (VEC[i][8])
                chk($sformatf("R%0d vec %0d len", VEC[i][21:18], i), int'(done_len), int'(VEC[i][6:0]));
        end
        rx_valid = 1'b0;

        // R6 readback of the last sentence
        rd_addr = 7'd0; #1;
        chk("R6 stored dollar", int'(rd_data), 8'h24);
        rd_addr = 7'd1; #1;
        chk("R6 stored G", int'(rd_data), 8'h47);

        // R9 exactly MAX payload bytes is delivered
        header();
        for (int i = 0; i < MAX; i++) begin
            step(1'b1, 8'h40 + 8'(i % 64));
            chk("R9 no overflow at limit", int'(overflow), 0);
        end
        step(1'b1, 8'h0D);
        step(1'b1, 8'h0A);
        chk("R9 full sentence done", int'(done), 1);
        chk("R9 full sentence len", int'(done_len), MAX);
        rx_valid = 1'b0;
        rd_addr = 7'd79; #1;
        chk("R6 last stored byte", int'(rd_data), 8'h4F);

        // R9 one byte more aborts
        header();
        for (int i = 0; i < MAX; i++) step(1'b1, 8'h41);
        step(1'b1, 8'h42);
        chk("R9 overflow pulse", int'(overflow), 1);
        chk("R9 no done on overflow", int'(done), 0);
        step(1'b1, 8'h7A);
        chk("R9 overflow single cycle", int'(overflow), 0);
        step(1'b1, 8'h0D);
        step(1'b1, 8'h0A);
        chk("R9 back in hunt after overflow", int'(done), 0);
        rx_valid = 1'b0;

        // R10 illegal state encoding
        force u_sentence_framer.u_ctrl.state_q = framer_pkg::state_t'(3'd7);
        @(posedge clk);
        #1 release u_sentence_framer.u_ctrl.state_q;
        @(negedge clk);
        chk("R10 state_err raised", int'(state_err), 1);
        @(negedge clk);
        @(negedge clk);
        chk("R10 state_err cleared", int'(state_err), 0);
        header();
        step(1'b1, 8'h61);
        step(1'b1, 8'h0D);
        step(1'b1, 8'h0A);
        chk("R10 recovered done", int'(done), 1);
        chk("R10 recovered len", int'(done_len), 1);
        rx_valid = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule